// File: doc/BRIEF.md
# Transaction Intermediate Checkpoint Unit

This unit splits a hardware transaction into at most two subtransactions. The split is a single intermediate checkpoint, placed just before an access that is expected to conflict. When the transaction is later aborted, only the unsafe part has to be re-executed; the work done before the first conflicting access is kept. The unit keeps read and write marks per cache line for each subtransaction, a snapshot of the register state taken at the checkpoint, and a flag saying whether the checkpoint can still be used.

A checkpoint is taken when the coherence response for an access reports a conflict with a remote speculative writer, or when an external conflict predictor flags the access. The checkpoint may stop being usable when the second subtransaction overwrites a line that the first one had already written. With `USE_LOG=1` the old value is saved in an undo log, and on a partial rollback the log is replayed newest entry first on a write port while `busy` is high. If the log is full, the checkpoint is dropped instead of stalling. With `USE_LOG=0` any such overwrite drops the checkpoint at once. On abort the unit selects the restart point: the checkpoint when it is valid and the conflicting line was untouched before it, and otherwise the start of the transaction.

Top module: `txn_ckpt_unit`

## Requirements
- R1: After reset and after `tx_begin` in the idle phase, `in_sub1`, `ckpt_valid`, `busy`, `restart_full` and `restart_ckpt` are 0. After `tx_begin`, `in_tx` is 1 and every line queries as `q_marks` = 0.
- R2: In subtransaction 0, an access with `acc_conflict` or `acc_predict` set takes the checkpoint on that edge. `in_sub1` and `ckpt_valid` become 1 and `restart_regs` holds the `regs_in` value of that cycle. The flagged access itself belongs to subtransaction 1. Flags seen later in the same transaction take no new snapshot.
- R3: A read sets the SR mark and a write sets the SW mark of the current subtransaction for `acc_line`. `q_marks` for `q_line` reads {sr0, sw0, sr1, sw1} at bits 3..0.
- R4: An abort taken in subtransaction 1 with a valid checkpoint, where `abort_line` has no subtransaction 0 mark, pulses `restart_ckpt` for one cycle on the next edge. The unit clears every sr1/sw1 mark, keeps the sr0/sw0 marks, and stays in the transaction with `in_sub1` and `ckpt_valid` at 1.
- R5: Any other abort pulses `restart_full` for one cycle and returns the unit to idle with all marks, the log and `ckpt_valid` cleared. This covers an abort in subtransaction 0, an abort on a line marked in subtransaction 0, and an abort with the checkpoint invalid.
- R6: With the log, the first subtransaction 1 write to a line with sw0 set and sw1 clear, while the checkpoint is valid, records (line, `acc_old_data`). Further writes to that line record nothing.
- R7: On a partial rollback the log entries appear on `undo_valid`/`undo_line`/`undo_data`, one per cycle and newest first. They start together with the `restart_ckpt` pulse. `busy` is high exactly during those cycles, and the log is empty afterwards.
- R8: With the log full, a further overwrite clears `ckpt_valid` instead of stalling.
- R9: Without the log, any overwrite as in R6 clears `ckpt_valid`.
- R10: `tx_commit` clears all marks, the log and `ckpt_valid`, and returns the unit to idle. It takes priority over an abort in the same cycle, and an abort takes priority over an access.
- R11: Accesses presented while idle have no effect on the marks or on the checkpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin | input | 1 | Start a transaction (idle only) |
| tx_commit | input | 1 | Commit the running transaction |
| tx_abort | input | 1 | Abort request for the running transaction |
| abort_line | input | LW | Line whose conflict caused the abort |
| acc_valid | input | 1 | Transactional access this cycle |
| acc_write | input | 1 | Access is a write |
| acc_line | input | LW | Line index of the access |
| acc_old_data | input | DW | Current line value before the write |
| acc_conflict | input | 1 | Coherence reported a remote speculative writer |
| acc_predict | input | 1 | Predictor flags the access as likely conflicting |
| regs_in | input | RW | Register state to snapshot |
| q_line | input | LW | Line to query |
| q_marks | output | 4 | {sr0, sw0, sr1, sw1} of `q_line` |
| in_tx | output | 1 | Transaction running |
| in_sub1 | output | 1 | Checkpoint taken, second subtransaction running |
| ckpt_valid | output | 1 | Checkpoint usable for rollback |
| busy | output | 1 | Undo replay in progress |
| restart_full | output | 1 | Pulse: restart from transaction start |
| restart_ckpt | output | 1 | Pulse: restart from checkpoint |
| restart_regs | output | RW | Register snapshot of the checkpoint |
| undo_valid | output | 1 | Replay write valid |
| undo_line | output | LW | Replay write line |
| undo_data | output | DW | Replay write old value |

## Verification
The assertions assume that no access, abort or commit is presented while `busy` is high, and that `tx_begin` arrives only while idle. The bench keeps to this by waiting out every replay before it drives the next input and by starting a transaction only after a commit or a full restart. Random transactions use a small line space so that overwrites, checkpoint flags and sub-0-marked abort lines occur often. Directed cases fill the four-entry log and drive simultaneous abort and access.

// File: rtl/txn_ckpt_pkg.sv
package txn_ckpt_pkg;

  typedef enum logic {PH_IDLE, PH_RUN} phase_e;

  typedef struct packed {
    logic sr0;
    logic sw0;
    logic sr1;
    logic sw1;
  } line_marks_t;

  // checkpoint is inserted before a flagged access, only once per transaction
  function automatic logic ckpt_trigger(logic in_sub1, logic conf, logic pred);
    return !in_sub1 && (conf || pred);
  endfunction

  // later subtransaction writes a line the earlier one already wrote (first time only)
  function automatic logic is_overwrite(logic eff_sub1, logic wr, logic sw0, logic sw1);
    return eff_sub1 && wr && sw0 && !sw1;
  endfunction

  // rollback to checkpoint allowed only if the conflict lies wholly after it
  function automatic logic partial_ok(logic in_sub1, logic valid, logic sub0_mark);
    return in_sub1 && valid && !sub0_mark;
  endfunction

endpackage

// File: rtl/txn_line_marks.sv
module txn_line_marks
  import txn_ckpt_pkg::*;
#(
  parameter int NLINES = 16,
  localparam int LW = $clog2(NLINES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              clr_sub1,
  input  logic              set_en,
  input  logic              set_sub1,
  input  logic              set_wr,
  input  logic [LW-1:0]     set_line,
  input  logic [LW-1:0]     q_line,
  output logic [NLINES-1:0] sw0,
  output logic [NLINES-1:0] sw1,
  output logic [NLINES-1:0] any0,
  output logic [3:0]        q_marks
);

  line_marks_t marks_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic hit;
    assign hit = set_en && (set_line == LW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        marks_q[g] <= '0;
      end else if (clr_all) begin
        marks_q[g] <= '0;
      end else if (clr_sub1) begin
        marks_q[g].sr1 <= 1'b0;
        marks_q[g].sw1 <= 1'b0;
      end else if (hit) begin
        if (set_sub1 &&  set_wr) marks_q[g].sw1 <= 1'b1;
        if (set_sub1 && !set_wr) marks_q[g].sr1 <= 1'b1;
        if (!set_sub1 &&  set_wr) marks_q[g].sw0 <= 1'b1;
        if (!set_sub1 && !set_wr) marks_q[g].sr0 <= 1'b1;
      end
    end

    assign sw0[g]  = marks_q[g].sw0;
    assign sw1[g]  = marks_q[g].sw1;
    assign any0[g] = marks_q[g].sr0 | marks_q[g].sw0;

    // R10: a wipe leaves the line with no marks
    a_r10_wipe_clears: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (marks_q[g] == '0));

    // R4: partial rollback keeps sub-0 marks and drops sub-1 marks
    a_r4_keep_sub0: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sub1 && !clr_all) |=> (marks_q[g].sr0 == $past(marks_q[g].sr0)) &&
                                 (marks_q[g].sw0 == $past(marks_q[g].sw0)) &&
                                 !marks_q[g].sr1 && !marks_q[g].sw1);
  end

  assign q_marks = marks_q[q_line];

endmodule

// File: rtl/txn_undo_log.sv
module txn_undo_log #(
  parameter int DEPTH = 128,
  parameter int LW    = 4,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [LW-1:0] push_line,
  input  logic [DW-1:0] push_data,
  input  logic          start,
  output logic          full,
  output logic          rep_valid,
  output logic [LW-1:0] rep_line,
  output logic [DW-1:0] rep_data
);

  logic [LW-1:0] line_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [PW-1:0] cnt_q;
  logic [IW-1:0] ridx_q;
  logic          replaying_q;
  logic          empty;
  logic          do_push;

  assign full    = (cnt_q == PW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !replaying_q && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      ridx_q      <= '0;
      replaying_q <= 1'b0;
    end else if (clear) begin
      cnt_q       <= '0;
      replaying_q <= 1'b0;
    end else if (replaying_q) begin
      if (ridx_q == '0) begin
        replaying_q <= 1'b0;
        cnt_q       <= '0;
      end else begin
        ridx_q <= ridx_q - IW'(1);
      end
    end else if (start && !empty) begin
      replaying_q <= 1'b1;
      ridx_q      <= IW'(cnt_q - PW'(1));
    end else if (do_push) begin
      cnt_q <= cnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      line_mem[IW'(cnt_q)] <= push_line;
      data_mem[IW'(cnt_q)] <= push_data;
    end
  end

  assign rep_valid = replaying_q;
  assign rep_line  = line_mem[ridx_q];
  assign rep_data  = data_mem[ridx_q];

  // R8: the log is never asked to accept an entry when full
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R7: replay walks strictly newest to oldest
  a_r7_reverse_order: assert property (@(posedge clk) disable iff (!rst_n)
    (replaying_q && $past(replaying_q) && !$past(clear)) |-> (ridx_q == $past(ridx_q) - IW'(1)));

endmodule

// File: rtl/txn_ckpt_unit.sv
module txn_ckpt_unit
  import txn_ckpt_pkg::*;
#(
  parameter int NLINES    = 16,
  parameter int DW        = 32,
  parameter int RW        = 64,
  parameter bit USE_LOG   = 1'b1,
  parameter int LOG_DEPTH = 128,
  localparam int LW = $clog2(NLINES)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_begin,
  input  logic          tx_commit,
  input  logic          tx_abort,
  input  logic [LW-1:0] abort_line,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [LW-1:0] acc_line,
  input  logic [DW-1:0] acc_old_data,
  input  logic          acc_conflict,
  input  logic          acc_predict,
  input  logic [RW-1:0] regs_in,
  input  logic [LW-1:0] q_line,
  output logic [3:0]    q_marks,
  output logic          in_tx,
  output logic          in_sub1,
  output logic          ckpt_valid,
  output logic          busy,
  output logic          restart_full,
  output logic          restart_ckpt,
  output logic [RW-1:0] restart_regs,
  output logic          undo_valid,
  output logic [LW-1:0] undo_line,
  output logic [DW-1:0] undo_data
);

  phase_e        phase_q;
  logic          in_sub1_q, valid_q, rfull_q, rckpt_q;
  logic [RW-1:0] snap_q;

  logic [NLINES-1:0] sw0, sw1, any0;
  logic running, do_commit, do_abort, do_acc;
  logic take, eff_sub1, eff_valid, overwrite;
  logic log_full, log_room, log_push, ckpt_kill;
  logic go_partial, go_full, wipe;

  // internal events, named for the assertions
  assign running    = (phase_q == PH_RUN) && !busy;
  assign do_commit  = running && tx_commit;
  assign do_abort   = running && tx_abort && !tx_commit;
  assign do_acc     = running && acc_valid && !tx_commit && !tx_abort;
  assign take       = do_acc && ckpt_trigger(in_sub1_q, acc_conflict, acc_predict);
  assign eff_sub1   = in_sub1_q | take;
  assign eff_valid  = valid_q | take;
  assign overwrite  = do_acc && is_overwrite(eff_sub1, acc_write, sw0[acc_line], sw1[acc_line]);
  assign log_room   = USE_LOG ? !log_full : 1'b0;
  assign log_push   = overwrite && eff_valid && log_room;
  assign ckpt_kill  = overwrite && eff_valid && !log_room;
  assign go_partial = do_abort && partial_ok(in_sub1_q, valid_q, any0[abort_line]);
  assign go_full    = do_abort && !go_partial;
  assign wipe       = do_commit || go_full || ((phase_q == PH_IDLE) && tx_begin);

  txn_line_marks #(.NLINES(NLINES)) u_marks (
    .clk, .rst_n,
    .clr_all  (wipe),
    .clr_sub1 (go_partial),
    .set_en   (do_acc),
    .set_sub1 (eff_sub1),
    .set_wr   (acc_write),
    .set_line (acc_line),
    .q_line,
    .sw0, .sw1, .any0,
    .q_marks
  );

  if (USE_LOG) begin : g_log
    txn_undo_log #(.DEPTH(LOG_DEPTH), .LW(LW), .DW(DW)) u_log (
      .clk, .rst_n,
      .clear     (wipe),
      .push      (log_push),
      .push_line (acc_line),
      .push_data (acc_old_data),
      .start     (go_partial),
      .full      (log_full),
      .rep_valid (undo_valid),
      .rep_line  (undo_line),
      .rep_data  (undo_data)
    );
  end else begin : g_nolog
    assign log_full   = 1'b1;
    assign undo_valid = 1'b0;
    assign undo_line  = '0;
    assign undo_data  = '0;
  end

  assign busy = undo_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      in_sub1_q <= 1'b0;
      valid_q   <= 1'b0;
      rfull_q   <= 1'b0;
      rckpt_q   <= 1'b0;
      snap_q    <= '0;
    end else begin
      rfull_q <= go_full;
      rckpt_q <= go_partial;
      if ((phase_q == PH_IDLE) && tx_begin) phase_q <= PH_RUN;
      else if (do_commit || go_full)        phase_q <= PH_IDLE;
      if (wipe) begin
        in_sub1_q <= 1'b0;
        valid_q   <= 1'b0;
      end else begin
        if (take) in_sub1_q <= 1'b1;
        if (ckpt_kill)  valid_q <= 1'b0;
        else if (take)  valid_q <= 1'b1;
      end
      if (take) snap_q <= regs_in;
    end
  end

  assign in_tx        = (phase_q == PH_RUN);
  assign in_sub1      = in_sub1_q;
  assign ckpt_valid   = valid_q;
  assign restart_full = rfull_q;
  assign restart_ckpt = rckpt_q;
  assign restart_regs = snap_q;

  // R2: entering subtransaction 1 always follows a flagged access
  a_r2_ckpt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sub1) |-> $past(acc_valid && (acc_conflict || acc_predict)));

  // R4: a rollback to the checkpoint leaves the checkpoint usable
  a_r4_ckpt_kept: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ckpt |-> (in_tx && in_sub1 && ckpt_valid));

  // R5: restart kinds are exclusive and a full restart leaves the unit idle
  a_r5_full_idle: assert property (@(posedge clk) disable iff (!rst_n)
    restart_full |-> (!restart_ckpt && !in_tx && !ckpt_valid && !in_sub1));

  // R9: without a log no replay ever happens
  a_r9_no_replay: assert property (@(posedge clk) disable iff (!rst_n)
    !USE_LOG |-> !busy);

  // R10: commit returns to idle with nothing left
  a_r10_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tx && !busy && tx_commit) |=> (!in_tx && !ckpt_valid && !in_sub1));

  // R7: inputs stay quiet during replay (environment assumption)
  a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(acc_valid || tx_abort || tx_commit));

endmodule

// File: tb/txn_ckpt_unit_tb.sv
module txn_ckpt_unit_tb;
  localparam int NL = 16, DW = 8, RW = 16, DEP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_begin = 0, tx_commit = 0, tx_abort = 0, acc_valid = 0, acc_write = 0;
  logic acc_conflict = 0, acc_predict = 0;
  logic [3:0] abort_line = '0, acc_line = '0, q_line = '0;
  logic [DW-1:0] acc_old_data = '0;
  logic [RW-1:0] regs_in = '0;

  logic [3:0] qm_a, qm_b, ul_a, ul_b;
  logic tx_a, tx_b, s1_a, s1_b, cv_a, cv_b, bz_a, bz_b, rf_a, rf_b, rc_a, rc_b, uv_a, uv_b;
  logic [RW-1:0] rr_a, rr_b;
  logic [DW-1:0] ud_a, ud_b;

  always #5 clk = ~clk;

  txn_ckpt_unit #(.NLINES(NL), .DW(DW), .RW(RW), .USE_LOG(1'b1), .LOG_DEPTH(DEP)) u_dut (
    .clk, .rst_n, .tx_begin, .tx_commit, .tx_abort, .abort_line, .acc_valid, .acc_write,
    .acc_line, .acc_old_data, .acc_conflict, .acc_predict, .regs_in, .q_line,
    .q_marks(qm_a), .in_tx(tx_a), .in_sub1(s1_a), .ckpt_valid(cv_a), .busy(bz_a),
    .restart_full(rf_a), .restart_ckpt(rc_a), .restart_regs(rr_a),
    .undo_valid(uv_a), .undo_line(ul_a), .undo_data(ud_a));

  txn_ckpt_unit #(.NLINES(NL), .DW(DW), .RW(RW), .USE_LOG(1'b0), .LOG_DEPTH(DEP)) u_nolog (
    .clk, .rst_n, .tx_begin, .tx_commit, .tx_abort, .abort_line, .acc_valid, .acc_write,
    .acc_line, .acc_old_data, .acc_conflict, .acc_predict, .regs_in, .q_line,
    .q_marks(qm_b), .in_tx(tx_b), .in_sub1(s1_b), .ckpt_valid(cv_b), .busy(bz_b),
    .restart_full(rf_b), .restart_ckpt(rc_b), .restart_regs(rr_b),
    .undo_valid(uv_b), .undo_line(ul_b), .undo_data(ud_b));

  int checks = 0, errors = 0;

  // bench model
  bit m_sr0[NL], m_sw0[NL], m_sr1[NL], m_sw1[NL];
  bit m_in1, m_cva, m_cvb;
  int m_cnt;
  logic [3:0] m_ll[DEP];
  logic [DW-1:0] m_ld[DEP];
  logic [RW-1:0] m_snap;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_marks(input int l);
    return {m_sr0[l], m_sw0[l], m_sr1[l], m_sw1[l]};
  endfunction

  function automatic bit exp_partial(input bit cv, input int l);
    return m_in1 && cv && !(m_sr0[l] || m_sw0[l]);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NL; i++) begin
      m_sr0[i] = 0; m_sw0[i] = 0; m_sr1[i] = 0; m_sw1[i] = 0;
    end
    m_in1 = 0; m_cva = 0; m_cvb = 0; m_cnt = 0;
  endtask

  task automatic begin_tx();
    tx_begin = 1;
    @(negedge clk);
    tx_begin = 0;
    model_clear();
    chk("R1 in_tx", {30'd0, tx_a, tx_b}, 32'h3);
    chk("R1 sub1/valid", {28'd0, s1_a, cv_a, s1_b, cv_b}, 32'h0);
    q_line = 4'($urandom_range(0, NL - 1));
    #1;
    chk("R1 marks", {28'd0, qm_a}, 32'h0);
  endtask

  task automatic access(input bit wr, input int l, input bit c, input bit p,
                        input logic [DW-1:0] od, input logic [RW-1:0] rg);
    bit take, es, ow;
    acc_valid = 1; acc_write = wr; acc_line = 4'(l); acc_conflict = c; acc_predict = p;
    acc_old_data = od; regs_in = rg; q_line = 4'(l);
    @(negedge clk);
    acc_valid = 0; acc_conflict = 0; acc_predict = 0;
    take = !m_in1 && (c || p);
    es = m_in1 || take;
    if (take) begin m_in1 = 1; m_cva = 1; m_cvb = 1; m_snap = rg; end
    ow = es && wr && m_sw0[l] && !m_sw1[l];
    if (ow && m_cva) begin
      if (m_cnt < DEP) begin m_ll[m_cnt] = 4'(l); m_ld[m_cnt] = od; m_cnt++; end
      else m_cva = 0;
    end
    if (ow) m_cvb = 0;
    if (wr) begin if (es) m_sw1[l] = 1; else m_sw0[l] = 1; end
    else    begin if (es) m_sr1[l] = 1; else m_sr0[l] = 1; end
    chk("R3 marks", {28'd0, qm_a}, {28'd0, exp_marks(l)});
    chk("R3 marks nolog", {28'd0, qm_b}, {28'd0, exp_marks(l)});
    chk("R2 in_sub1", {31'd0, s1_a}, {31'd0, m_in1});
    chk("R6 R8 ckpt_valid log", {31'd0, cv_a}, {31'd0, m_cva});
    chk("R9 ckpt_valid nolog", {31'd0, cv_b}, {31'd0, m_cvb});
    if (m_in1) chk("R2 snapshot", {16'd0, rr_a}, {16'd0, m_snap});
  endtask

  // abort, check restart choice and replay, then commit to close
  task automatic abort_close(input int l, input bit with_acc);
    bit pa, pb;
    pa = exp_partial(m_cva, l);
    pb = exp_partial(m_cvb, l);
    tx_abort = 1; abort_line = 4'(l);
    acc_valid = with_acc; acc_write = 1; acc_line = 4'((l + 1) % NL);
    q_line = 4'((l + 1) % NL);
    @(negedge clk);
    tx_abort = 0; acc_valid = 0;
    chk("R4 restart_ckpt log", {31'd0, rc_a}, {31'd0, pa});
    chk("R5 restart_full log", {31'd0, rf_a}, {31'd0, !pa});
    chk("R4 R5 restart nolog", {30'd0, rc_b, rf_b}, {30'd0, pb, !pb});
    if (with_acc && pa)
      chk("R10 access dropped on abort", {30'd0, qm_a[1:0]}, '0);
    if (pa) begin
      chk("R4 regs", {16'd0, rr_a}, {16'd0, m_snap});
      chk("R4 stays in sub1", {29'd0, tx_a, s1_a, cv_a}, 32'h7);
      for (int i = m_cnt - 1; i >= 0; i--) begin
        chk("R7 replay entry", {19'd0, bz_a, uv_a, ul_a, ud_a},
            {19'd0, 1'b1, 1'b1, m_ll[i], m_ld[i]});
        @(negedge clk);
      end
      chk("R7 busy low after replay", {31'd0, bz_a}, 32'h0);
      for (int i = 0; i < NL; i++) begin m_sr1[i] = 0; m_sw1[i] = 0; end
      q_line = 4'(l); #1;
      chk("R4 sub0 kept sub1 cleared", {28'd0, qm_a}, {28'd0, exp_marks(l)});
    end else begin
      chk("R5 idle after full", {30'd0, tx_a, cv_a}, 32'h0);
      chk("R5 marks cleared", {28'd0, qm_a}, 32'h0);
    end
    tx_commit = 1;
    @(negedge clk);
    tx_commit = 0;
    model_clear();
    chk("R10 idle after commit", {28'd0, tx_a, cv_a, tx_b, cv_b}, 32'h0);
    chk("R10 marks cleared", {28'd0, qm_a}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset state", {26'd0, tx_a, s1_a, cv_a, bz_a, rf_a, rc_a}, 32'h0);

    // R11: access while idle
    acc_valid = 1; acc_write = 1; acc_line = 4'd3; acc_conflict = 1; q_line = 4'd3;
    @(negedge clk);
    acc_valid = 0; acc_conflict = 0;
    chk("R11 idle access no ckpt", {29'd0, s1_a, cv_a, tx_a}, 32'h0);
    chk("R11 idle access no mark", {28'd0, qm_a}, 32'h0);

    // directed: checkpoint, overwrite logged once, partial rollback
    begin_tx();
    access(0, 1, 0, 0, 8'h11, 16'h0001);
    access(1, 2, 0, 0, 8'h22, 16'h0002);
    access(1, 2, 0, 1, 8'h5a, 16'hbeef);
    access(1, 2, 0, 0, 8'h77, 16'h0003);
    access(0, 3, 1, 0, 8'h33, 16'hcafe);
    chk("R2 no second snapshot", {16'd0, rr_a}, 32'h0000beef);
    chk("R6 one entry logged", m_cnt, 1);
    abort_close(7, 1'b1);

    // directed: fill the log, then overflow drops the checkpoint
    begin_tx();
    for (int i = 0; i < 5; i++) access(1, i, 0, 0, 8'(i), 16'h0);
    access(0, 9, 1, 0, 8'h0, 16'h1234);
    for (int i = 0; i < 4; i++) access(1, i, 0, 0, 8'(8'h40 + i), 16'h0);
    chk("R8 still valid at full", {31'd0, cv_a}, 32'h1);
    access(1, 4, 0, 0, 8'h44, 16'h0);
    chk("R8 overflow invalidates", {31'd0, cv_a}, 32'h0);
    abort_close(9, 1'b0);

    // directed: full log replay of four entries
    begin_tx();
    for (int i = 0; i < 4; i++) access(1, i + 4, 0, 0, 8'(i), 16'h0);
    access(0, 12, 0, 1, 8'h0, 16'h4321);
    for (int i = 3; i >= 0; i--) access(1, i + 4, 0, 0, 8'(8'h90 + i), 16'h0);
    abort_close(13, 1'b0);

    // directed: abort in subtransaction 0, and on a sub-0 line after checkpoint
    begin_tx();
    access(0, 5, 0, 0, 8'h0, 16'h0);
    abort_close(6, 1'b0);
    begin_tx();
    access(0, 5, 0, 0, 8'h0, 16'h0);
    access(0, 6, 1, 0, 8'h0, 16'h0abc);
    abort_close(5, 1'b0);

    // random transactions
    for (int t = 0; t < 40; t++) begin
      int n;
      begin_tx();
      n = $urandom_range(3, 14);
      for (int k = 0; k < n; k++)
        access(1'($urandom_range(0, 1)), $urandom_range(0, 7),
               $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
               8'($urandom), 16'($urandom));
      abort_close($urandom_range(0, 9), 1'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule